// File: doc/BRIEF.md
# Fault-Hardened Register File

This block is a 32-entry, 32-bit register file with two combinational read ports and one synchronous write port. It is built to expose fault injection rather than to tolerate it. Entry 0 is hardwired to zero. Every other entry is stored together with seven single-error-correct, double-error-detect check bits. These bits are computed when the word is written and verified whenever a read port selects the word. A flipped bit is reported but never repaired.

The selection logic itself is watched as well. Each binary read address is turned into a one-hot select vector, and the word is picked by an AND-OR multiplexer. The write side also works from a decoded per-entry enable vector. A checker on each of these vectors demands exactly one set bit when its port is in use and no set bit when it is idle. All one-hot and check-bit violations are combined, and the result appears one clock later on a single major alert output. A surrounding core uses the read data exactly as it would use a plain register file. The alert goes to the chip's escalation logic.

Top module: `hard_regfile`

## Requirements
- R1: After reset every entry reads as zero on both ports and the alert output is low.
- R2: A word written with the write enable high at a rising edge is returned on both read ports from the following cycle onward.
- R3: Address 0 always reads as zero, and a write to address 0 changes nothing.
- R4: A read port whose enable is low returns zero regardless of its address.
- R5: With the write enable low, the write address and data have no effect on any entry.
- R6: A read of the entry being written in the same cycle returns the old contents, and the new contents appear after the clock edge.
- R7: A per-entry write enable vector with two or more set bits raises the alert in the next cycle.
- R8: A decoded read select vector that is not exactly one-hot while its port is enabled raises the alert in the next cycle.
- R9: Each storage entry holds data in bits [31:0] and check bits in [38:32]. A single flipped bit in a read entry raises the alert in the next cycle, and the read data carries the flipped bit uncorrected.
- R10: Two flipped bits in a read entry raise the alert in the next cycle.
- R11: A corrupted entry that no enabled port selects does not raise the alert.
- R12: The alert is a registered copy of the current fault flags. It is low in the cycle a fault appears, high in the next, and low again one cycle after the fault is gone. It stays low during fault-free operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 5 | Entry to write |
| wr_data_i | input | 32 | Data to write |
| rd_a_en_i | input | 1 | Read port A enable |
| rd_a_addr_i | input | 5 | Read port A address |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_en_i | input | 1 | Read port B enable |
| rd_b_addr_i | input | 5 | Read port B address |
| rd_b_data_o | output | 32 | Read port B data |
| alert_major_o | output | 1 | Registered major alert |

## Verification
A corrupted stored word, or a glitched select or enable vector, becomes visible on alert_major_o exactly one rising edge after an enabled port touches it. A corrupted entry that nobody reads stays silent until it is selected. A bad entry also shows at once on the read data, because detection never rewrites the word. A lost write or a wrong decode shows up as stale or mixed data on the next read of that entry. The bench therefore forces faults into the storage and the decoded vectors. It then samples both the data and the alert in the same cycle and in the cycle after.

// File: rtl/hard_rf_pkg.sv
package hard_rf_pkg;

    localparam int unsigned RF_DW   = 32;
    localparam int unsigned RF_REGS = 32;
    localparam int unsigned RF_HB   = 6;
    localparam int unsigned RF_CW   = RF_DW + RF_HB + 1;

    typedef logic [RF_CW-1:0] rf_word_t;

    // Hamming part: data bit j sits at the j-th codeword position that is
    // not a power of two (starting at 3); check bit i covers positions with bit i set.
    function automatic logic [RF_HB-1:0] rf_hamming(logic [RF_DW-1:0] d);
        logic [RF_HB-1:0] c;
        logic [31:0]      p;
        c = '0;
        p = 32'd2;
        for (int j = 0; j < RF_DW; j++) begin
            p = p + 32'd1;
            if ((p & (p - 32'd1)) == 32'd0) p = p + 32'd1;
            for (int i = 0; i < RF_HB; i++) begin
                if (p[i]) c[i] = c[i] ^ d[j];
            end
        end
        return c;
    endfunction

    function automatic rf_word_t rf_encode(logic [RF_DW-1:0] d);
        logic [RF_HB-1:0] h;
        h = rf_hamming(d);
        return {^{h, d}, h, d};
    endfunction

    function automatic logic rf_bad(rf_word_t w);
        logic [RF_HB-1:0] syn;
        syn = rf_hamming(w[RF_DW-1:0]) ^ w[RF_DW +: RF_HB];
        return (|syn) | (^w);
    endfunction

endpackage

// File: rtl/hard_rf_dec.sv
module hard_rf_dec #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    output logic [N-1:0]  oh_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign oh_o[i] = en_i && (addr_i == AW'(i));
    end
endmodule

// File: rtl/hard_rf_ohchk.sv
module hard_rf_ohchk #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] vec_i,
    input  logic         want_i,
    output logic         bad_o
);
    logic [N:0] seen;
    logic [N:0] multi;

    assign seen[0]  = 1'b0;
    assign multi[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_scan
        assign seen[i+1]  = seen[i] | vec_i[i];
        assign multi[i+1] = multi[i] | (seen[i] & vec_i[i]);
    end

    assign bad_o = multi[N] | (seen[N] != want_i);
endmodule

// File: rtl/hard_rf_mux.sv
module hard_rf_mux #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 39
) (
    input  logic [N-1:0][W-1:0] din_i,
    input  logic [N-1:0]        sel_i,
    output logic [W-1:0]        dout_o
);
    always_comb begin
        dout_o = '0;
        for (int unsigned i = 0; i < N; i++) begin
            dout_o = dout_o | (din_i[i] & {W{sel_i[i]}});
        end
    end
endmodule

// File: rtl/hard_rf_secded_chk.sv
module hard_rf_secded_chk
    import hard_rf_pkg::*;
(
    input  rf_word_t word_i,
    output logic     err_o
);
    assign err_o = rf_bad(word_i);
endmodule

// File: rtl/hard_regfile.sv
module hard_regfile
    import hard_rf_pkg::*;
#(
    parameter int unsigned NUM_REGS = RF_REGS
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [$clog2(NUM_REGS)-1:0]  wr_addr_i,
    input  logic [RF_DW-1:0]             wr_data_i,
    input  logic                         rd_a_en_i,
    input  logic [$clog2(NUM_REGS)-1:0]  rd_a_addr_i,
    output logic [RF_DW-1:0]             rd_a_data_o,
    input  logic                         rd_b_en_i,
    input  logic [$clog2(NUM_REGS)-1:0]  rd_b_addr_i,
    output logic [RF_DW-1:0]             rd_b_data_o,
    output logic                         alert_major_o
);
    localparam int unsigned AW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0]            wen_dec;
    logic [NUM_REGS-1:0]            wen_oh;
    logic [NUM_REGS-1:0]            rsel_a_oh;
    logic [NUM_REGS-1:0]            rsel_b_oh;
    logic [NUM_REGS-1:0][RF_CW-1:0] mem_d;
    logic [NUM_REGS-1:0][RF_CW-1:0] mem_q;
    rf_word_t                       wr_cw;
    rf_word_t                       rd_a_cw;
    rf_word_t                       rd_b_cw;
    logic                           wr_req;
    logic                           wen_bad;
    logic                           rsel_a_bad;
    logic                           rsel_b_bad;
    logic                           ecc_err_a;
    logic                           ecc_err_b;
    logic                           alert_d;
    logic                           alert_q;

    // ---------------- write side ----------------
    hard_rf_dec #(.N(NUM_REGS), .AW(AW)) u_wdec (
        .en_i   (wr_en_i),
        .addr_i (wr_addr_i),
        .oh_o   (wen_dec)
    );

    always_comb begin
        wen_oh    = wen_dec;
        wen_oh[0] = 1'b0;
    end

    assign wr_req = wr_en_i && (wr_addr_i != '0);
    assign wr_cw  = rf_encode(wr_data_i);

    hard_rf_ohchk #(.N(NUM_REGS)) u_wchk (
        .vec_i  (wen_oh),
        .want_i (wr_req),
        .bad_o  (wen_bad)
    );

    // ---------------- read port A ----------------
    hard_rf_dec #(.N(NUM_REGS), .AW(AW)) u_adec (
        .en_i   (rd_a_en_i),
        .addr_i (rd_a_addr_i),
        .oh_o   (rsel_a_oh)
    );

    hard_rf_ohchk #(.N(NUM_REGS)) u_achk (
        .vec_i  (rsel_a_oh),
        .want_i (rd_a_en_i),
        .bad_o  (rsel_a_bad)
    );

    hard_rf_mux #(.N(NUM_REGS), .W(RF_CW)) u_amux (
        .din_i  (mem_q),
        .sel_i  (rsel_a_oh),
        .dout_o (rd_a_cw)
    );

    hard_rf_secded_chk u_aecc (
        .word_i (rd_a_cw),
        .err_o  (ecc_err_a)
    );

    // ---------------- read port B ----------------
    hard_rf_dec #(.N(NUM_REGS), .AW(AW)) u_bdec (
        .en_i   (rd_b_en_i),
        .addr_i (rd_b_addr_i),
        .oh_o   (rsel_b_oh)
    );

    hard_rf_ohchk #(.N(NUM_REGS)) u_bchk (
        .vec_i  (rsel_b_oh),
        .want_i (rd_b_en_i),
        .bad_o  (rsel_b_bad)
    );

    hard_rf_mux #(.N(NUM_REGS), .W(RF_CW)) u_bmux (
        .din_i  (mem_q),
        .sel_i  (rsel_b_oh),
        .dout_o (rd_b_cw)
    );

    hard_rf_secded_chk u_becc (
        .word_i (rd_b_cw),
        .err_o  (ecc_err_b)
    );

    // ---------------- next state ----------------
    always_comb begin
        mem_d = mem_q;
        for (int unsigned i = 1; i < NUM_REGS; i++) begin
            if (wen_oh[i]) mem_d[i] = wr_cw;
        end
        mem_d[0] = '0;
        alert_d  = wen_bad | wen_oh[0]
                 | rsel_a_bad | rsel_b_bad
                 | (rd_a_en_i & ecc_err_a)
                 | (rd_b_en_i & ecc_err_b);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mem_q   <= '0;
            alert_q <= 1'b0;
        end else begin
            mem_q   <= mem_d;
            alert_q <= alert_d;
        end
    end

    assign rd_a_data_o   = rd_a_cw[RF_DW-1:0];
    assign rd_b_data_o   = rd_b_cw[RF_DW-1:0];
    assign alert_major_o = alert_q;

endmodule

// File: rtl/hard_regfile_chk.sv
module hard_regfile_chk #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          rd_a_en_i,
    input logic [AW-1:0] rd_a_addr_i,
    input logic [DW-1:0] rd_a_data_o,
    input logic          rd_b_en_i,
    input logic [DW-1:0] rd_b_data_o,
    input logic [N-1:0]  wen_oh,
    input logic [N-1:0]  rsel_a_oh,
    input logic          ecc_err_a,
    input logic          alert_major_o
);
    // R4
    idle_a_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_a_en_i |-> (rd_a_data_o == '0));

    // R4
    idle_b_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_b_en_i |-> (rd_b_data_o == '0));

    // R3
    reg0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_a_en_i && rd_a_addr_i == '0 && $countones(rsel_a_oh) == 1)
            |-> (rd_a_data_o == '0));

    // R7
    wen_multi_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(wen_oh) > 1) |=> alert_major_o);

    // R8
    rsel_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_a_en_i && $countones(rsel_a_oh) != 1) |=> alert_major_o);

    // R9
    ecc_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_a_en_i && ecc_err_a) |=> alert_major_o);
endmodule

bind hard_regfile hard_regfile_chk #(
    .N  (NUM_REGS),
    .AW ($clog2(NUM_REGS)),
    .DW (hard_rf_pkg::RF_DW)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_a_en_i     (rd_a_en_i),
    .rd_a_addr_i   (rd_a_addr_i),
    .rd_a_data_o   (rd_a_data_o),
    .rd_b_en_i     (rd_b_en_i),
    .rd_b_data_o   (rd_b_data_o),
    .wen_oh        (wen_oh),
    .rsel_a_oh     (rsel_a_oh),
    .ecc_err_a     (ecc_err_a),
    .alert_major_o (alert_major_o)
);

// File: tb/hard_regfile_tb.sv
module hard_regfile_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        rd_a_en_i = 1'b0;
    logic [4:0]  rd_a_addr_i = '0;
    logic [31:0] rd_a_data_o;
    logic        rd_b_en_i = 1'b0;
    logic [4:0]  rd_b_addr_i = '0;
    logic [31:0] rd_b_data_o;
    logic        alert_major_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [32];
    logic [31:0][38:0] snap;

    always #5 clk_i = ~clk_i;

    hard_regfile u_dut (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_a_en_i     (rd_a_en_i),
        .rd_a_addr_i   (rd_a_addr_i),
        .rd_a_data_o   (rd_a_data_o),
        .rd_b_en_i     (rd_b_en_i),
        .rd_b_addr_i   (rd_b_addr_i),
        .rd_b_data_o   (rd_b_data_o),
        .alert_major_o (alert_major_o)
    );

    // {address, data}
    localparam logic [36:0] VEC [0:7] = '{
        {5'd1,  32'h0000_0001},
        {5'd31, 32'hFFFF_FFFF},
        {5'd0,  32'hDEAD_BEEF},
        {5'd7,  32'h1234_5678},
        {5'd9,  32'h8000_0000},
        {5'd16, 32'hA5A5_5A5A},
        {5'd3,  32'h0F0F_F0F0},
        {5'd5,  32'h7654_3210}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
        if (a != 5'd0) model[a] = d;
    endtask

    task automatic read_both(input string req, input logic [4:0] a, input logic [4:0] b);
        @(negedge clk_i);
        rd_a_en_i = 1'b1; rd_a_addr_i = a;
        rd_b_en_i = 1'b1; rd_b_addr_i = b;
        #1;
        check(req, rd_a_data_o, model[a]);
        check(req, rd_b_data_o, model[b]);
    endtask

    task automatic ports_idle();
        @(negedge clk_i);
        rd_a_en_i = 1'b0; rd_b_en_i = 1'b0; wr_en_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R1: reset contents and alert
        for (int i = 0; i < 32; i++) read_both("R1", 5'(i), 5'(31 - i));
        check("R1 alert", {31'd0, alert_major_o}, 32'd0);

        // R2 / R3: table of writes, each read back on both ports
        for (int k = 0; k < 8; k++) begin
            do_write(VEC[k][36:32], VEC[k][31:0]);
            read_both(VEC[k][36:32] == 5'd0 ? "R3" : "R2", VEC[k][36:32], VEC[k][36:32]);
        end
        for (int i = 0; i < 32; i++) read_both("R2 sweep", 5'(i), 5'((i + 7) % 32));
        read_both("R3", 5'd0, 5'd0);

        // R5: write data present but enable low
        ports_idle();
        wr_addr_i = 5'd7; wr_data_i = 32'hCAFE_F00D;
        @(negedge clk_i);
        read_both("R5", 5'd7, 5'd7);

        // R6: same-cycle read of entry being written
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = 5'd6; wr_data_i = 32'h6666_0006;
        rd_a_en_i = 1'b1; rd_a_addr_i = 5'd6;
        #1 check("R6 old", rd_a_data_o, model[6]);
        @(negedge clk_i);
        wr_en_i = 1'b0;
        model[6] = 32'h6666_0006;
        #1 check("R6 new", rd_a_data_o, model[6]);

        // R4: disabled ports return zero
        @(negedge clk_i);
        rd_a_en_i = 1'b0; rd_a_addr_i = 5'd31;
        rd_b_en_i = 1'b0; rd_b_addr_i = 5'd7;
        #1;
        check("R4 port A", rd_a_data_o, 32'd0);
        check("R4 port B", rd_b_data_o, 32'd0);

        // R12: fault-free traffic leaves alert low
        @(negedge clk_i); #1;
        check("R12 quiet", {31'd0, alert_major_o}, 32'd0);

        // R7: two-hot write enable
        @(negedge clk_i);
        wr_data_i = 32'h5A5A_C3C3;
        force u_dut.wen_oh = 32'h0000_0014;
        #1 check("R12 same cycle", {31'd0, alert_major_o}, 32'd0);
        @(negedge clk_i);
        release u_dut.wen_oh;
        model[2] = 32'h5A5A_C3C3; model[4] = 32'h5A5A_C3C3;
        #1 check("R7", {31'd0, alert_major_o}, 32'd1);
        @(negedge clk_i); #1;
        check("R12 clears", {31'd0, alert_major_o}, 32'd0);
        read_both("R7 words", 5'd2, 5'd4);

        // R8: two-hot read select on an enabled port
        @(negedge clk_i);
        rd_a_en_i = 1'b1; rd_a_addr_i = 5'd3;
        force u_dut.rsel_a_oh = 32'h0000_0028;
        @(negedge clk_i);
        release u_dut.rsel_a_oh;
        #1 check("R8", {31'd0, alert_major_o}, 32'd1);
        @(negedge clk_i); #1;
        check("R8 clears", {31'd0, alert_major_o}, 32'd0);

        // R9 / R11: single flip in entry 7, data bit 4, not yet read
        ports_idle();
        snap = u_dut.mem_q;
        snap[7][4] = ~snap[7][4];
        force u_dut.mem_q = snap;
        @(negedge clk_i);
        release u_dut.mem_q;
        rd_a_en_i = 1'b1; rd_a_addr_i = 5'd3;
        @(negedge clk_i); #1;
        check("R11 unread", {31'd0, alert_major_o}, 32'd0);
        @(negedge clk_i);
        rd_a_addr_i = 5'd7;
        #1 check("R9 uncorrected", rd_a_data_o, model[7] ^ 32'h0000_0010);
        @(negedge clk_i); #1;
        check("R9", {31'd0, alert_major_o}, 32'd1);

        // R10: double flip in entry 9 (data bit 0, check bit 33)
        ports_idle();
        snap = u_dut.mem_q;
        snap[9][0]  = ~snap[9][0];
        snap[9][33] = ~snap[9][33];
        force u_dut.mem_q = snap;
        @(negedge clk_i);
        release u_dut.mem_q;
        rd_b_en_i = 1'b1; rd_b_addr_i = 5'd9;
        @(negedge clk_i); #1;
        check("R10", {31'd0, alert_major_o}, 32'd1);

        // Repair and confirm clean state
        ports_idle();
        do_write(5'd7, 32'h0000_7777);
        do_write(5'd9, 32'h0000_9999);
        read_both("R2 repair", 5'd7, 5'd9);
        @(negedge clk_i); #1;
        check("R12 after repair", {31'd0, alert_major_o}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule